// File: doc/BRIEF.md
# Bit-Serial Signed Fractional Divider

This block divides one 20-bit two's-complement fraction by another. Both operands arrive on their own serial lines, one bit per clock. A word-sync pulse marks the first bit of each 20-bit frame. Inside the block, a non-restoring engine makes one quotient decision per clock. The quotient leaves on a single serial line. A flag beside it is high whenever the result cannot be represented. Each word is processed in three overlapping phases: capture, divide and emit. Because the phases overlap, a new operand pair can be accepted in every frame, and the block never stalls.

Each operand is a fraction with one sign bit and W-1 bits after the binary point, so its value is the integer code divided by 2^(W-1). The division works on magnitudes. A fixed correction then applies the sign of the result, or saturates it, just before the quotient is handed to the output shifter. Three engine registers hold the partial remainder, the divisor magnitude and the quotient being formed.

The engine state machine has three states:
- `DS_IDLE`: no operands have been captured since reset.
- `DS_STEP`: iterating; one add or subtract step is done per clock.
- `DS_DONE`: all W-1 quotient bits are formed, and the result is held until the next sync.

It has three transitions:
- *load*: any state goes to `DS_STEP` on a sync.
- *finish*: `DS_STEP` goes to `DS_DONE` after the last step.
- *hold*: `DS_DONE` stays in `DS_DONE` while no sync arrives.

Top module: `fracdiv_serial`

## Requirements
- R1: While reset is active, and through the first output frame after reset, `quo_so` and `ovf_o` are 0.
- R2: Serial words are LSB first. Bit i of each operand is presented i cycles after a cycle in which `word_sync` is 1. `word_sync` is high during the cycle that carries bit 0.
- R3: When |A| < |B| and the signs match, the quotient code is floor(|A|·2^(W-1)/|B|). Here A is the dividend and B the divisor, and `ovf_o` is 0.
- R4: When |A| < |B| and the signs differ, the quotient code is the two's-complement negation of that magnitude, so the result truncates toward zero.
- R5: When |A| ≥ |B| and B ≠ 0, `ovf_o` is 1. The quotient saturates to 0x7FFFF (most positive) if the signs match, and to 0x80000 (most negative) if they differ.
- R6: When B = 0, `ovf_o` is 1. The quotient is 0x7FFFF for a non-negative dividend and 0x80000 for a negative one.
- R7: `ovf_o` changes only on the clock edge at the end of a sync cycle. It stays constant for the whole output frame that it describes.
- R8: Operands framed by sync k are emitted LSB first in the frame that starts at sync k+2. Bit 0 appears in the cycle after that sync. The divide finishes inside the frame between those two syncs, so the engine is never mid-iteration when a sync arrives.
- R9: Once the first sync has occurred, `word_sync` pulses exactly once every W cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_sync | input | 1 | High in the cycle carrying bit 0 of each frame |
| dvd_si | input | 1 | Serial dividend, LSB first |
| dvs_si | input | 1 | Serial divisor, LSB first |
| quo_so | output | 1 | Serial quotient, LSB first |
| ovf_o | output | 1 | Overflow flag for the quotient frame currently being emitted |

## Verification
The checker assumes a strictly periodic sync: after the first pulse, one pulse every W cycles, and never a pulse shortened or skipped. Only under that rhythm can the 19 iteration steps be guaranteed to end before the next transfer. The stimulus drives sync from a free-running cycle counter, so this assumption always holds. All operand patterns, random or directed, are applied only on the data lines. Random pairs are swapped most of the time so that |A| < |B|. The directed pairs cover equal magnitudes, a zero divisor, a divisor of -1 and a dividend of -1.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_STEP = 2'd1,
        DS_DONE = 2'd2
    } dstate_e;
endpackage

// File: rtl/fracdiv_shift_in.sv
module fracdiv_shift_in #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sin,
    output logic [W-1:0] word
);
    // LSB-first: after W shifts the first bit sits at word[0]
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= {sin, word[W-1:1]};
    end
endmodule

// File: rtl/fracdiv_core.sv
module fracdiv_core
    import fracdiv_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output dstate_e      state,
    output logic [W-1:0] q_mag,
    output logic         q_neg,
    output logic         q_ovf
);
    localparam int RW = W + 2;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 2);

    dstate_e              nxt;
    logic signed [RW-1:0] rem;
    logic signed [RW-1:0] dsr;
    logic signed [RW-1:0] shifted;
    logic signed [RW-1:0] rnext;
    logic [CW-1:0]        cnt;
    logic [W:0]           a_mag;
    logic [W:0]           b_mag;

    function automatic logic [W:0] mag_of(input logic [W-1:0] v);
        logic [W:0] ext;
        ext = {v[W-1], v};
        return v[W-1] ? (~ext + 1'b1) : ext;
    endfunction

    assign a_mag   = mag_of(a_in);
    assign b_mag   = mag_of(b_in);
    assign shifted = {rem[RW-2:0], 1'b0};
    assign rnext   = rem[RW-1] ? (shifted + dsr) : (shifted - dsr);

    always_comb begin
        nxt = state;
        unique case (state)
            DS_IDLE: if (load) nxt = DS_STEP;
            DS_STEP: if (load) nxt = DS_STEP;
                     else if (cnt == LAST) nxt = DS_DONE;
            DS_DONE: if (load) nxt = DS_STEP;
            default: nxt = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            dsr   <= '0;
            q_mag <= '0;
            q_neg <= 1'b0;
            q_ovf <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            rem   <= {1'b0, a_mag};
            dsr   <= {1'b0, b_mag};
            q_mag <= '0;
            q_neg <= a_in[W-1] ^ b_in[W-1];
            q_ovf <= (b_mag == '0) || (a_mag >= b_mag);
            cnt   <= '0;
        end else if (state == DS_STEP) begin
            rem   <= rnext;
            q_mag <= {q_mag[W-2:0], ~rnext[RW-1]};
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fracdiv_shift_out.sv
module fracdiv_shift_out #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] q_mag,
    input  logic         q_neg,
    input  logic         q_ovf,
    output logic         quo_so,
    output logic         ovf_o
);
    localparam logic [W-1:0] POS_SAT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_SAT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] fixed;
    logic [W-1:0] osr;

    // final correction: sign application or saturation
    always_comb begin
        if (q_ovf)      fixed = q_neg ? NEG_SAT : POS_SAT;
        else if (q_neg) fixed = ~q_mag + 1'b1;
        else            fixed = q_mag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osr   <= '0;
            ovf_o <= 1'b0;
        end else if (load) begin
            osr   <= fixed;
            ovf_o <= q_ovf;
        end else begin
            osr   <= {1'b0, osr[W-1:1]};
        end
    end

    assign quo_so = osr[0];
endmodule

// File: rtl/fracdiv_serial.sv
module fracdiv_serial
    import fracdiv_pkg::*;
#(
    parameter int W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_sync,
    input  logic dvd_si,
    input  logic dvs_si,
    output logic quo_so,
    output logic ovf_o
);
    logic [W-1:0] dvd_word;
    logic [W-1:0] dvs_word;
    logic [W-1:0] core_q;
    logic         core_neg;
    logic         core_ovf;
    dstate_e      core_state;

    fracdiv_shift_in #(.W(W)) u_dvd (
        .clk(clk), .rst_n(rst_n), .sin(dvd_si), .word(dvd_word)
    );

    fracdiv_shift_in #(.W(W)) u_dvs (
        .clk(clk), .rst_n(rst_n), .sin(dvs_si), .word(dvs_word)
    );

    fracdiv_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(word_sync),
        .a_in(dvd_word), .b_in(dvs_word),
        .state(core_state), .q_mag(core_q),
        .q_neg(core_neg), .q_ovf(core_ovf)
    );

    fracdiv_shift_out #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(word_sync),
        .q_mag(core_q), .q_neg(core_neg), .q_ovf(core_ovf),
        .quo_so(quo_so), .ovf_o(ovf_o)
    );
endmodule

// File: rtl/fracdiv_serial_chk.sv
module fracdiv_serial_chk
    import fracdiv_pkg::*;
#(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         word_sync,
    input logic         quo_so,
    input logic         ovf_o,
    input logic [W-1:0] dvs_word,
    input logic         core_ovf,
    input dstate_e      core_state
);
    localparam int GW = $clog2(W) + 1;

    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (word_sync) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != {GW{1'b1}}) begin
            gap  <= gap + 1'b1;
        end
    end

    // R9
    sync_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sync && seen) |-> (gap == GW'(W - 1)));

    // R8
    divide_in_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sync && seen) |-> (core_state != DS_STEP));

    // R7
    ovf_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_sync |=> $stable(ovf_o));

    // R6
    zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sync && dvs_word == '0) |=> core_ovf);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!quo_so && !ovf_o));
endmodule

bind fracdiv_serial fracdiv_serial_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .word_sync(word_sync),
    .quo_so(quo_so), .ovf_o(ovf_o), .dvs_word(dvs_word),
    .core_ovf(core_ovf), .core_state(core_state)
);

// File: tb/fracdiv_serial_tb_top.sv
module fracdiv_serial_tb_top;
    localparam int W  = 20;
    localparam int NF = 300;
    localparam logic [W-1:0] MSK = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_sync = 1'b0;
    logic dvd_si = 1'b0;
    logic dvs_si = 1'b0;
    logic quo_so;
    logic ovf_o;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [W-1:0] a_arr [NF];
    logic [W-1:0] b_arr [NF];

    always #2 clk = ~clk;

    fracdiv_serial #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_sync(word_sync),
        .dvd_si(dvd_si), .dvs_si(dvs_si),
        .quo_so(quo_so), .ovf_o(ovf_o)
    );

    function automatic longint sval(input logic [W-1:0] v);
        return v[W-1] ? (longint'(v) - (longint'(1) << W)) : longint'(v);
    endfunction

    function automatic longint mag(input logic [W-1:0] v);
        longint s;
        s = sval(v);
        return (s < 0) ? -s : s;
    endfunction

    // returns {ovf, quotient}
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        longint ma, mb, qm;
        logic neg;
        logic [W-1:0] q;
        ma  = mag(a);
        mb  = mag(b);
        neg = a[W-1] ^ b[W-1];
        if (mb == 0 || ma >= mb) begin
            q = neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            return {1'b1, q};
        end
        qm = (ma << (W - 1)) / mb;
        q  = neg ? W'(-qm) : W'(qm);
        return {1'b0, q};
    endfunction

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual ovf=%0b q=%05h expected ovf=%0b q=%05h",
                     tag, act[W], act[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic put(input int k, input logic [W-1:0] a, input logic [W-1:0] b);
        a_arr[k] = a;
        b_arr[k] = b;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] col;
        logic ovf0;
        logic ovf_var;
        void'($urandom(32'h5eed_1234));
        // directed corners
        put(0, 20'h20000, 20'h40000);   // 0.25/0.5, R3
        put(1, 20'hE0000, 20'h40000);   // -0.25/0.5, R4
        put(2, 20'h20000, 20'hC0000);   // 0.25/-0.5, R4
        put(3, 20'h12345, 20'h80000);   // divisor -1, R4
        put(4, 20'h80000, 20'h80000);   // -1/-1, R5 positive sat
        put(5, 20'h12345, 20'h00000);   // R6 positive
        put(6, 20'hF1234, 20'h00000);   // R6 negative
        put(7, 20'h3A5A5, 20'h3A5A5);   // equal, R5
        put(8, 20'h00000, 20'h00123);   // zero dividend, R3
        put(9, 20'hC0000, 20'h40000);   // -0.5/0.5, R5 negative sat
        put(10, 20'h00001, 20'h7FFFF);  // tiny quotient, R3
        put(11, 20'h7FFFE, 20'h7FFFF);  // near one, R3
        for (int k = 12; k < NF; k++) begin
            logic [W-1:0] a, b, t;
            a = W'($urandom) & MSK;
            b = W'($urandom) & MSK;
            if (($urandom % 4) != 0 && mag(a) > mag(b)) begin
                t = a; a = b; b = t;
            end
            put(k, a, b);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet right after reset
        check("R1 reset", {ovf_o, {(W-1){1'b0}}, quo_so}, '0);

        col = '0;
        ovf0 = 1'b0;
        ovf_var = 1'b0;
        for (int t = 0; t <= (NF + 2) * W; t++) begin
            @(negedge clk);
            if (t > 0) begin
                int w, bi;
                w  = (t - 1) / W;
                bi = (t - 1) % W;
                col[bi] = quo_so;   // R2/R8: LSB first from cycle after sync
                if (bi == 0) begin
                    ovf0 = ovf_o;
                    ovf_var = 1'b0;
                end else if (ovf_o !== ovf0) begin
                    ovf_var = 1'b1;
                end
                if (bi == W - 1) begin
                    if (w == 0) begin
                        check("R1 first frame", {ovf0, col}, '0);
                    end else if (w >= 2 && w - 2 < NF) begin
                        logic [W:0] e;
                        string tag;
                        e = model(a_arr[w-2], b_arr[w-2]);
                        if (e[W])  tag = (b_arr[w-2] == '0) ? "R6" : "R5";
                        else       tag = (a_arr[w-2][W-1] ^ b_arr[w-2][W-1]) ? "R4" : "R3";
                        // R8: frame w carries operands of frame w-2
                        check($sformatf("%s R8 frame %0d", tag, w - 2), {ovf0, col}, e);
                        // R7: flag steady across the frame
                        check("R7 ovf steady", {ovf_var, {W{1'b0}}}, '0);
                    end
                end
            end
            begin
                int fr, bi;
                fr = t / W;
                bi = t % W;
                word_sync = (bi == 0);   // R9: one pulse every W cycles
                dvd_si = (fr < NF) ? a_arr[fr][bi] : 1'b0;
                dvs_si = (fr < NF) ? b_arr[fr][bi] : 1'b0;
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule